// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Generator

This block builds the descriptor table for one 32-bit scatter-gather DMA transfer in hardware, so that a processor does not have to fill it. The caller gives a buffer base address, a block count and a block size, then pulses a start input. The block multiplies the count by the block size to get the byte total. It splits the total into chunks of at most 64 KiB and writes one 64-bit descriptor per chunk into a local descriptor RAM, one entry per clock.

Each descriptor holds a chunk address, a 16-bit length and attribute bits. Only the final descriptor carries the end marker. A full 64 KiB chunk is written with a length field of zero, and a transfer shorter than one chunk still produces exactly one end-marked descriptor. After the last write the block pulses done and presents the address of table entry 0, ready to be loaded into the DMA engine's system-address register. If the transfer would need more entries than the table holds, the block pulses an error and writes nothing.

Top module: `sgt_builder`

## Requirements
- R1: After reset, busy_o, done_o, err_o and ram_we_o are 0 and sar_o is 0.
- R2: The byte total is blk_cnt_i times the low 12 bits of blk_size_i. Bits 15:12 of blk_size_i have no effect.
- R3: The descriptor count is 1 when the total is below 65536. Otherwise it is total/65536, plus 1 when total mod 65536 is non-zero.
- R4: Descriptors are written on consecutive cycles, starting the cycle after start_i is accepted in idle. Entry n goes to ram_idx_o = n, with the address field holding base + n*65536.
- R5: Descriptor word layout: bits 15:0 are the attribute, bits 31:16 the length and bits 63:32 the address. Every descriptor except the last has attribute 16'h0021 (transfer code 2'b10 in bits 5:4, valid in bit 0) and length 0, which means 65536 bytes.
- R6: The last descriptor has attribute 16'h0023 (transfer, end in bit 1, valid). Its length is total - (count-1)*65536, truncated to 16 bits.
- R7: done_o is high for exactly one cycle, the cycle after the last write. From then on sar_o equals the TABLE_BASE parameter (default 32'h0001_0000).
- R8: When the count exceeds DEPTH (default 32), err_o is high for exactly one cycle, the cycle after start. No descriptor is written and done_o stays low.
- R9: start_i is ignored while busy_o is high. A build in progress keeps the parameters it latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| buf_base_i | input | 32 | Buffer base address |
| blk_cnt_i | input | 16 | Number of blocks |
| blk_size_i | input | 16 | Block size field, low 12 bits used |
| busy_o | output | 1 | A build, done or error cycle is in progress |
| done_o | output | 1 | One-cycle pulse when the table is complete |
| err_o | output | 1 | One-cycle pulse when the table would overflow |
| sar_o | output | 32 | Table base address for the system-address register |
| ram_we_o | output | 1 | Descriptor RAM write enable |
| ram_idx_o | output | 5 | Descriptor RAM entry index |
| ram_wdata_o | output | 64 | Descriptor word |

## Verification
Assertions check on every cycle that:
- the write index starts at zero and steps by one between consecutive writes;
- done follows a write that carried the end bit, with sar_o equal to the table base;
- an error never overlaps or directly follows a write;
- done, error and write enable are mutually exclusive.

Only the bench scenarios can show that the descriptor count, chunk addresses and tail length are correct for a given input. These scenarios cover a single short block, an exact 64 KiB total, a total with a remainder, a masked block-size field, a full 32-entry table and an overflowing one. They also show that a second start during a build is ignored.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

    localparam int CHUNK_LOG2 = 16;
    localparam int LEN_W      = 16;
    localparam int ATTR_W     = 16;
    localparam int ADDR_W     = 32;

    localparam logic [ATTR_W-1:0] ATTR_VALID = 16'h0001;
    localparam logic [ATTR_W-1:0] ATTR_END   = 16'h0002;
    localparam logic [ATTR_W-1:0] ATTR_XFER  = 16'h0020;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [ATTR_W-1:0] attr;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DONE,
        ST_ERR
    } build_state_e;

    function automatic logic [ATTR_W-1:0] attr_for(input logic is_last);
        return is_last ? (ATTR_XFER | ATTR_END | ATTR_VALID) : (ATTR_XFER | ATTR_VALID);
    endfunction

endpackage

// File: rtl/sgt_chunk_plan.sv
module sgt_chunk_plan
    import sgt_pkg::*;
#(
    parameter int BCNT_W  = 16,
    parameter int BSIZE_W = 12,
    parameter int BSIN_W  = 16,
    localparam int TOT_W  = BCNT_W + BSIZE_W,
    localparam int CNT_W  = TOT_W - CHUNK_LOG2 + 1
) (
    input  logic [BCNT_W-1:0] blk_cnt,
    input  logic [BSIN_W-1:0] blk_size,
    output logic [TOT_W-1:0]  total,
    output logic [CNT_W-1:0]  n_desc,
    output logic [LEN_W-1:0]  tail_len
);
    logic [BSIZE_W-1:0]          size_m;
    logic [TOT_W-CHUNK_LOG2-1:0] whole;
    logic                        has_rem;

    always_comb begin
        size_m   = blk_size[BSIZE_W-1:0];
        total    = TOT_W'(blk_cnt) * TOT_W'(size_m);
        whole    = total[TOT_W-1:CHUNK_LOG2];
        has_rem  = |total[CHUNK_LOG2-1:0];
        tail_len = total[LEN_W-1:0];
        if (whole == '0)
            n_desc = CNT_W'(1);
        else
            n_desc = CNT_W'(whole) + CNT_W'(has_rem);
    end
endmodule

// File: rtl/sgt_desc_fmt.sv
module sgt_desc_fmt
    import sgt_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              is_last,
    input  logic [LEN_W-1:0]  tail_len,
    output desc_t             desc
);
    always_comb begin
        desc.attr = attr_for(is_last);
        desc.len  = is_last ? tail_len : '0;
        desc.addr = base + (ADDR_W'(idx) << CHUNK_LOG2);
    end
endmodule

// File: rtl/sgt_builder.sv
module sgt_builder
    import sgt_pkg::*;
#(
    parameter int          DEPTH      = 32,
    parameter logic [31:0] TABLE_BASE = 32'h0001_0000,
    localparam int         IDX_W      = $clog2(DEPTH),
    localparam int         TOT_W      = 28,
    localparam int         CNT_W      = TOT_W - CHUNK_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [31:0]      buf_base_i,
    input  logic [15:0]      blk_cnt_i,
    input  logic [15:0]      blk_size_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [31:0]      sar_o,
    output logic             ram_we_o,
    output logic [IDX_W-1:0] ram_idx_o,
    output logic [63:0]      ram_wdata_o
);
    build_state_e      state_q;
    logic [TOT_W-1:0]  total_w;
    logic [CNT_W-1:0]  n_desc_w;
    logic [LEN_W-1:0]  tail_w;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  tail_q;
    logic [IDX_W-1:0]  last_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       sar_q;
    logic              is_last;
    desc_t             desc_w;

    sgt_chunk_plan #(.BCNT_W(16), .BSIZE_W(12), .BSIN_W(16)) plan_i (
        .blk_cnt (blk_cnt_i),
        .blk_size(blk_size_i),
        .total   (total_w),
        .n_desc  (n_desc_w),
        .tail_len(tail_w)
    );

    assign is_last = (idx_q == last_q);

    sgt_desc_fmt #(.IDX_W(IDX_W)) fmt_i (
        .base    (base_q),
        .idx     (idx_q),
        .is_last (is_last),
        .tail_len(tail_q),
        .desc    (desc_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            tail_q  <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            sar_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    if (n_desc_w > CNT_W'(DEPTH)) begin
                        state_q <= ST_ERR;
                    end else begin
                        state_q <= ST_WRITE;
                        base_q  <= buf_base_i;
                        tail_q  <= tail_w;
                        last_q  <= IDX_W'(n_desc_w - CNT_W'(1));
                        idx_q   <= '0;
                    end
                end
                ST_WRITE: begin
                    if (is_last) begin
                        state_q <= ST_DONE;
                        sar_q   <= TABLE_BASE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign err_o       = (state_q == ST_ERR);
    assign sar_o       = sar_q;
    assign ram_we_o    = (state_q == ST_WRITE);
    assign ram_idx_o   = idx_q;
    assign ram_wdata_o = desc_w;

    // R4: index steps by one between back-to-back writes
    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (ram_we_o && $past(ram_we_o)) |-> ram_idx_o == $past(ram_idx_o) + IDX_W'(1));

    // R4: a write burst begins at entry 0
    a_r4_first_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_o) |-> ram_idx_o == '0);

    // R7: done follows an end-marked write and presents the table base
    a_r7_done_after_end: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(ram_we_o) && $past(ram_wdata_o[1]) && sar_o == TABLE_BASE));

    // R8: an error neither overlaps nor directly follows a write
    a_r8_err_no_write: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!ram_we_o && !$past(ram_we_o)));

    // R7, R8: done, error and write enable are mutually exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o, ram_we_o}));

endmodule

// File: tb/sgt_builder_tb.sv
module sgt_builder_tb_top;
    localparam logic [31:0] TBASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] buf_base_i = '0;
    logic [15:0] blk_cnt_i = '0;
    logic [15:0] blk_size_i = '0;
    logic        busy_o, done_o, err_o, ram_we_o;
    logic [31:0] sar_o;
    logic [4:0]  ram_idx_o;
    logic [63:0] ram_wdata_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sgt_builder dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .buf_base_i(buf_base_i),
        .blk_cnt_i(blk_cnt_i), .blk_size_i(blk_size_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .sar_o(sar_o), .ram_we_o(ram_we_o),
        .ram_idx_o(ram_idx_o), .ram_wdata_o(ram_wdata_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // One build: compute expected table from R2/R3/R5/R6, check writes (R4), done and sar (R7).
    // retrig: pulse start with other inputs during write 1 (R9).
    task automatic run_case(input string tag, input logic [31:0] base,
                            input logic [15:0] cnt, input logic [15:0] size, input bit retrig);
        longint total = longint'(cnt) * longint'(size & 16'h0FFF);
        int n = (total < 65536) ? 1 : int'(total / 65536) + ((total % 65536) != 0 ? 1 : 0);
        @(negedge clk);
        buf_base_i = base; blk_cnt_i = cnt; blk_size_i = size; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [63:0] exp;
            logic        last = (k == n - 1);
            logic [15:0] len = last ? 16'(total - longint'(n - 1) * 65536) : 16'h0000;
            exp = {base + 32'(k) * 32'h0001_0000, len, last ? 16'h0023 : 16'h0021};
            chk({tag, " R4 we"}, 64'(ram_we_o), 64'd1);
            chk({tag, " R4 idx"}, 64'(ram_idx_o), 64'(k));
            chk({tag, last ? " R6 last word" : " R5 word"}, ram_wdata_o, exp);
            if (retrig && k == 1) begin
                buf_base_i = 32'hDEAD_0000; blk_cnt_i = 16'd1; blk_size_i = 16'd8; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk({tag, " R3 no extra write"}, 64'(ram_we_o), 64'd0);
        chk({tag, " R7 done"}, 64'(done_o), 64'd1);
        chk({tag, " R7 sar"}, 64'(sar_o), 64'(TBASE));
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, 64'(done_o), 64'd0);
        chk({tag, " R9 idle after"}, 64'(busy_o), 64'd0);
        chk({tag, " R9 no write after"}, 64'(ram_we_o), 64'd0);
    endtask

    task automatic run_overflow(input logic [15:0] cnt, input logic [15:0] size);
        @(negedge clk);
        buf_base_i = 32'h2000_0000; blk_cnt_i = cnt; blk_size_i = size; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 err pulse", 64'(err_o), 64'd1);
        chk("R8 no write", 64'(ram_we_o), 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 err cleared", 64'(err_o), 64'd0);
            chk("R8 no write later", 64'(ram_we_o), 64'd0);
            chk("R8 no done", 64'(done_o), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 64'(busy_o), 64'd0);
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 err", 64'(err_o), 64'd0);
        chk("R1 we", 64'(ram_we_o), 64'd0);
        chk("R1 sar", 64'(sar_o), 64'd0);
        run_overflow(16'd4097, 16'd512);
        run_case("R3 short", 32'h4000_0000, 16'd1, 16'd512, 1'b0);
        run_case("R3 exact64k", 32'h4010_0000, 16'd128, 16'd512, 1'b0);
        run_case("R3 remainder", 32'h8000_1000, 16'd300, 16'd512, 1'b0);
        run_case("R2 masked size", 32'h0000_0040, 16'd2, 16'hF200, 1'b0);
        run_case("R9 retrigger", 32'h1234_0000, 16'd300, 16'd512, 1'b1);
        run_case("R4 full table", 32'h9000_0000, 16'd4096, 16'd512, 1'b0);
        run_case("R6 odd tail", 32'h0000_0003, 16'd7, 16'd4095, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule